// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

The block keeps track of a large set of numbered interrupt vectors (256 by default). It holds three bit arrays: one for vectors waiting to be taken, one for vectors currently being serviced, and one recording whether each vector was raised as a level or an edge source. The highest pending vector is compared against a processor priority, and the block decides whether that vector may be handed to the processor. The processor priority combines a software-written task priority with the class of the highest vector in service. A vector's class is its upper four bits.

Sources raise a vector with a set strobe that carries the vector number and its trigger mode. A level source that drops clears its pending bit with a deassert strobe. The processor takes an interrupt with an acknowledge strobe. In that same cycle the block returns either a granted vector, the spurious vector (a vector is pending but blocked by priority), or nothing. The processor ends service with an end-of-interrupt strobe. That strobe retires the highest in-service vector. For a level vector it also raises a broadcast strobe toward the interrupt sources, unless a suppression bit in the configuration register is set. A software enable bit in the configuration register gates all presentation.

Presentation is classified each cycle into one of four states:
- PRES_OFF: software enable is clear.
- PRES_IDLE: enabled, with nothing pending.
- PRES_HELD: a vector is pending but blocked by priority.
- PRES_READY: a vector is pending and deliverable.

The state follows the arrays directly and needs no stored state of its own. A set strobe moves the block from PRES_IDLE to HELD or READY. A grant, a deassert, a task-priority write or an end-of-interrupt can move it from READY to HELD or IDLE, or from HELD to READY. A configuration write moves it into or out of PRES_OFF.

Top module: `ivc_controller`

## Requirements
- R1: After reset the request, in-service and trigger arrays are empty and the task priority is 0. The configuration holds spurious vector 0xFF with enable and suppression clear. While reset is applied, irq is 0, ppr is 0 and acknowledge returns nothing.
- R2: A set strobe sets the pending bit of set_vec in the next cycle. It also sets that vector's trigger bit when set_level is 1 and clears it when set_level is 0.
- R3: The pending vector considered is the highest-numbered pending bit. An acknowledge grants that vector ahead of any lower one.
- R4: ppr equals the task priority when tpr[7:4] is at least the class of the highest in-service vector. Otherwise ppr equals that class shifted left by four. An empty in-service array counts as class 0.
- R5: irq is 1 exactly when software enable is set, a vector is pending, and either ppr is 0 or the pending vector's class is strictly above ppr[7:4]. irq follows every array or register change with no added cycle.
- R6: An acknowledge while a vector is pending but blocked returns ack_vld=1, ack_spur=1 and ack_vec equal to configuration bits [7:0]. It changes no array.
- R7: An acknowledge with no vector pending returns ack_vld=0 and ack_vec=0.
- R8: An acknowledge of a deliverable vector returns ack_vld=1, ack_spur=0 and the vector. In the next cycle that vector's pending bit is cleared and its in-service bit is set.
- R9: An end-of-interrupt clears the highest in-service bit. In the same cycle eoi_bcast=1 and eoi_vec equal to that vector, if and only if the vector's trigger bit is 1 and configuration bit 12 (suppression) is 0.
- R10: An end-of-interrupt with an empty in-service array changes nothing and raises no broadcast.
- R11: Configuration bit 8 is the software enable. While it is 0, irq is 0 and acknowledge returns nothing. A configuration write stores bits [8:0] and bit 12.
- R12: A deassert strobe clears the pending bit of deassert_vec in the next cycle.
- R13: Acknowledge and end-of-interrupt act on the state before the cycle's updates. When one bit is both set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_vld | input | 1 | Raise a vector |
| set_vec | input | 8 | Vector to raise |
| set_level | input | 1 | 1 = level source, 0 = edge source |
| deassert_vld | input | 1 | Level source dropped |
| deassert_vec | input | 8 | Vector whose pending bit is cleared |
| tpr_wr | input | 1 | Task priority write |
| tpr_val | input | 8 | New task priority |
| cfg_wr | input | 1 | Configuration write |
| cfg_val | input | 13 | [7:0] spurious vector, [8] enable, [12] broadcast suppression |
| ack_req | input | 1 | Processor acknowledge |
| eoi_req | input | 1 | End of interrupt |
| irq | output | 1 | Deliverable vector present |
| ack_vld | output | 1 | Acknowledge returned a vector |
| ack_spur | output | 1 | Returned vector is the spurious vector |
| ack_vec | output | 8 | Returned vector |
| ppr | output | 8 | Processor priority |
| eoi_bcast | output | 1 | End-of-interrupt broadcast strobe |
| eoi_vec | output | 8 | Vector being broadcast |

## Verification
An acknowledge and an end-of-interrupt can land in the same cycle, and so can a new set strobe and an acknowledge. In both cases the result must come from the state before the cycle, with set winning over clear on a shared bit. The bench provokes these pairings directly: a grant alongside the retirement of a lower in-service vector, a set arriving while an acknowledge finds the array empty, and a set and a deassert on one vector. Random traffic then produces many more collisions. Each output and the following cycle's ppr and irq are judged against a bench model that applies the same pre-state rule.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    parameter int unsigned IVC_VECTORS = 256;
    parameter int unsigned IVC_WORD    = 32;
    parameter int unsigned IVC_CLASS_W = 4;

    typedef enum logic [1:0] {
        PRES_OFF   = 2'd0,
        PRES_IDLE  = 2'd1,
        PRES_HELD  = 2'd2,
        PRES_READY = 2'd3
    } pres_e;
endpackage

// File: rtl/ivc_bitvec.sv
module ivc_bitvec #(
    parameter int unsigned N      = 256,
    parameter int unsigned WORD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [$clog2(N)-1:0] set_idx,
    input  logic                 clr_a_en,
    input  logic [$clog2(N)-1:0] clr_a_idx,
    input  logic                 clr_b_en,
    input  logic [$clog2(N)-1:0] clr_b_idx,
    output logic [N-1:0]         bits
);
    localparam int unsigned IW = $clog2(N);
    localparam int unsigned OW = $clog2(WORD_W);
    localparam int unsigned SW = IW - OW;
    localparam int unsigned NW = N / WORD_W;

    for (genvar w = 0; w < NW; w++) begin : g_word
        localparam logic [SW-1:0] WSEL = SW'(w);
        logic [WORD_W-1:0] q;
        logic [WORD_W-1:0] set_m;
        logic [WORD_W-1:0] clr_m;

        always_comb begin
            set_m = '0;
            clr_m = '0;
            if (set_en && set_idx[IW-1:OW] == WSEL)
                set_m[set_idx[OW-1:0]] = 1'b1;
            if (clr_a_en && clr_a_idx[IW-1:OW] == WSEL)
                clr_m[clr_a_idx[OW-1:0]] = 1'b1;
            if (clr_b_en && clr_b_idx[IW-1:OW] == WSEL)
                clr_m[clr_b_idx[OW-1:0]] = 1'b1;
        end

        // set has precedence over any clear of the same bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else
                q <= (q & ~clr_m) | set_m;
        end

        assign bits[w*WORD_W +: WORD_W] = q;
    end
endmodule

// File: rtl/ivc_top_find.sv
module ivc_top_find #(
    parameter int unsigned N      = 256,
    parameter int unsigned WORD_W = 32
) (
    input  logic [N-1:0]         bits,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int unsigned IW = $clog2(N);
    localparam int unsigned OW = $clog2(WORD_W);
    localparam int unsigned SW = IW - OW;
    localparam int unsigned NW = N / WORD_W;

    logic [NW-1:0] w_any;
    logic [OW-1:0] w_pos [NW];

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [OW-1:0] pos;
        always_comb begin
            pos = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits[w*WORD_W + b])
                    pos = OW'(b);
            end
        end
        assign w_any[w] = |bits[w*WORD_W +: WORD_W];
        assign w_pos[w] = pos;
    end

    // higher words override lower ones, giving the highest set index
    always_comb begin
        any = |w_any;
        idx = '0;
        for (int w = 0; w < NW; w++) begin
            if (w_any[w])
                idx = {SW'(w), w_pos[w]};
        end
    end
endmodule

// File: rtl/ivc_prio_gate.sv
module ivc_prio_gate #(
    parameter int unsigned IW = 8,
    parameter int unsigned CW = 4
) (
    input  logic [IW-1:0] tpr,
    input  logic          isr_any,
    input  logic [IW-1:0] isr_top,
    input  logic          irr_any,
    input  logic [IW-1:0] irr_top,
    output logic [IW-1:0] ppr,
    output logic          ready,
    output logic          held
);
    localparam int unsigned LOW = IW - CW;

    logic [CW-1:0] isr_cls;
    logic [CW-1:0] tpr_cls;
    logic [CW-1:0] irr_cls;

    always_comb begin
        isr_cls = isr_any ? isr_top[IW-1:LOW] : '0;
        tpr_cls = tpr[IW-1:LOW];
        irr_cls = irr_top[IW-1:LOW];
        if (tpr_cls >= isr_cls)
            ppr = tpr;
        else
            ppr = {isr_cls, {LOW{1'b0}}};
        ready = irr_any && ((ppr == '0) || (irr_cls > ppr[IW-1:LOW]));
        held  = irr_any && !ready;
    end
endmodule

// File: rtl/ivc_controller.sv
module ivc_controller import ivc_pkg::*; #(
    parameter int unsigned N      = IVC_VECTORS,
    parameter int unsigned WORD_W = IVC_WORD
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_vld,
    input  logic [$clog2(N)-1:0]   set_vec,
    input  logic                   set_level,
    input  logic                   deassert_vld,
    input  logic [$clog2(N)-1:0]   deassert_vec,
    input  logic                   tpr_wr,
    input  logic [$clog2(N)-1:0]   tpr_val,
    input  logic                   cfg_wr,
    input  logic [$clog2(N)+4:0]   cfg_val,
    input  logic                   ack_req,
    input  logic                   eoi_req,
    output logic                   irq,
    output logic                   ack_vld,
    output logic                   ack_spur,
    output logic [$clog2(N)-1:0]   ack_vec,
    output logic [$clog2(N)-1:0]   ppr,
    output logic                   eoi_bcast,
    output logic [$clog2(N)-1:0]   eoi_vec
);
    localparam int unsigned IW      = $clog2(N);
    localparam int unsigned EN_BIT  = IW;
    localparam int unsigned SUP_BIT = IW + 4;

    logic [IW-1:0] tpr_q;
    logic [IW:0]   spur_q;
    logic          sup_q;
    logic          sw_en;

    logic [N-1:0]  irr_bits;
    logic [N-1:0]  isr_bits;
    logic [N-1:0]  tmr_bits;
    logic          irr_any;
    logic          isr_any;
    logic [IW-1:0] irr_top;
    logic [IW-1:0] isr_top;
    logic          gate_ready;
    logic          gate_held;
    logic          grant;
    logic          eoi_pop;
    pres_e         pres;

    // configuration and task priority registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tpr_q  <= '0;
            spur_q <= {1'b0, {IW{1'b1}}};
            sup_q  <= 1'b0;
        end else begin
            if (tpr_wr)
                tpr_q <= tpr_val;
            if (cfg_wr) begin
                spur_q <= cfg_val[EN_BIT:0];
                sup_q  <= cfg_val[SUP_BIT];
            end
        end
    end

    assign sw_en = spur_q[EN_BIT];

    ivc_bitvec #(.N(N), .WORD_W(WORD_W)) u_irr (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (set_vld),
        .set_idx   (set_vec),
        .clr_a_en  (grant),
        .clr_a_idx (irr_top),
        .clr_b_en  (deassert_vld),
        .clr_b_idx (deassert_vec),
        .bits      (irr_bits)
    );

    ivc_bitvec #(.N(N), .WORD_W(WORD_W)) u_isr (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (grant),
        .set_idx   (irr_top),
        .clr_a_en  (eoi_pop),
        .clr_a_idx (isr_top),
        .clr_b_en  (1'b0),
        .clr_b_idx ({IW{1'b0}}),
        .bits      (isr_bits)
    );

    ivc_bitvec #(.N(N), .WORD_W(WORD_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (set_vld && set_level),
        .set_idx   (set_vec),
        .clr_a_en  (set_vld && !set_level),
        .clr_a_idx (set_vec),
        .clr_b_en  (1'b0),
        .clr_b_idx ({IW{1'b0}}),
        .bits      (tmr_bits)
    );

    ivc_top_find #(.N(N), .WORD_W(WORD_W)) u_find_irr (
        .bits (irr_bits),
        .any  (irr_any),
        .idx  (irr_top)
    );

    ivc_top_find #(.N(N), .WORD_W(WORD_W)) u_find_isr (
        .bits (isr_bits),
        .any  (isr_any),
        .idx  (isr_top)
    );

    ivc_prio_gate #(.IW(IW), .CW(IVC_CLASS_W)) u_gate (
        .tpr     (tpr_q),
        .isr_any (isr_any),
        .isr_top (isr_top),
        .irr_any (irr_any),
        .irr_top (irr_top),
        .ppr     (ppr),
        .ready   (gate_ready),
        .held    (gate_held)
    );

    // presentation state, derived every cycle from the stored arrays
    always_comb begin
        if (!sw_en)
            pres = PRES_OFF;
        else if (gate_ready)
            pres = PRES_READY;
        else if (gate_held)
            pres = PRES_HELD;
        else
            pres = PRES_IDLE;
    end

    // outputs per presentation state
    always_comb begin
        ack_vld  = 1'b0;
        ack_spur = 1'b0;
        ack_vec  = '0;
        grant    = 1'b0;
        irq      = 1'b0;
        unique case (pres)
            PRES_OFF, PRES_IDLE: begin
            end
            PRES_HELD: begin
                if (ack_req) begin
                    ack_vld  = 1'b1;
                    ack_spur = 1'b1;
                    ack_vec  = spur_q[IW-1:0];
                end
            end
            PRES_READY: begin
                irq = 1'b1;
                if (ack_req) begin
                    ack_vld = 1'b1;
                    ack_vec = irr_top;
                    grant   = 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        eoi_pop   = eoi_req && isr_any;
        eoi_bcast = eoi_pop && tmr_bits[isr_top] && !sup_q;
        eoi_vec   = eoi_bcast ? isr_top : '0;
    end
endmodule

// File: rtl/ivc_controller_chk.sv
module ivc_controller_chk #(
    parameter int unsigned N  = 256,
    parameter int unsigned IW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          set_vld,
    input logic [IW-1:0] set_vec,
    input logic          ack_req,
    input logic          eoi_req,
    input logic          irq,
    input logic          ack_vld,
    input logic          ack_spur,
    input logic [IW-1:0] ack_vec,
    input logic [IW-1:0] ppr,
    input logic          eoi_bcast,
    input logic [IW-1:0] tpr_q,
    input logic          sw_en,
    input logic          sup_q,
    input logic [N-1:0]  irr_bits
);
    localparam int unsigned LOW = IW - 4;

    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |=> irr_bits[$past(set_vec)]);

    p_ppr_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ppr[IW-1:LOW] >= tpr_q[IW-1:LOW]) && ((ppr == tpr_q) || (ppr[LOW-1:0] == '0)));

    p_grant_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && !ack_spur) |-> ((ppr == '0) || (ack_vec[IW-1:LOW] > ppr[IW-1:LOW])));

    p_ack_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && irr_bits == '0) |-> !ack_vld);

    p_grant_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && !ack_spur && !(set_vld && set_vec == ack_vec)) |=> !irr_bits[$past(ack_vec)]);

    p_bcast_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast |-> (eoi_req && !sup_q));

    p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |-> (!irq && !ack_vld));
endmodule

bind ivc_controller ivc_controller_chk #(.N(N), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vld   (set_vld),
    .set_vec   (set_vec),
    .ack_req   (ack_req),
    .eoi_req   (eoi_req),
    .irq       (irq),
    .ack_vld   (ack_vld),
    .ack_spur  (ack_spur),
    .ack_vec   (ack_vec),
    .ppr       (ppr),
    .eoi_bcast (eoi_bcast),
    .tpr_q     (tpr_q),
    .sw_en     (sw_en),
    .sup_q     (sup_q),
    .irr_bits  (irr_bits)
);

// File: tb/ivc_controller_bench.sv
module ivc_controller_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_vld = 1'b0;
    logic [7:0]  set_vec = '0;
    logic        set_level = 1'b0;
    logic        deassert_vld = 1'b0;
    logic [7:0]  deassert_vec = '0;
    logic        tpr_wr = 1'b0;
    logic [7:0]  tpr_val = '0;
    logic        cfg_wr = 1'b0;
    logic [12:0] cfg_val = '0;
    logic        ack_req = 1'b0;
    logic        eoi_req = 1'b0;
    logic        irq;
    logic        ack_vld;
    logic        ack_spur;
    logic [7:0]  ack_vec;
    logic [7:0]  ppr;
    logic        eoi_bcast;
    logic [7:0]  eoi_vec;

    int n_chk = 0;
    int n_bad = 0;

    bit [255:0] m_irr, m_isr, m_tmr;
    bit [7:0]   m_tpr;
    bit [8:0]   m_spur;
    bit         m_sup;

    always #5 clk = ~clk;

    ivc_controller u_ivc_controller (
        .clk(clk), .rst_n(rst_n),
        .set_vld(set_vld), .set_vec(set_vec), .set_level(set_level),
        .deassert_vld(deassert_vld), .deassert_vec(deassert_vec),
        .tpr_wr(tpr_wr), .tpr_val(tpr_val),
        .cfg_wr(cfg_wr), .cfg_val(cfg_val),
        .ack_req(ack_req), .eoi_req(eoi_req),
        .irq(irq), .ack_vld(ack_vld), .ack_spur(ack_spur), .ack_vec(ack_vec),
        .ppr(ppr), .eoi_bcast(eoi_bcast), .eoi_vec(eoi_vec)
    );

    function automatic int top_of(bit [255:0] v);
        for (int i = 255; i >= 0; i--)
            if (v[i]) return i;
        return -1;
    endfunction

    function automatic int exp_ppr();
        int ic;
        int t;
        t  = top_of(m_isr);
        ic = (t < 0) ? 0 : (t >> 4);
        if ((m_tpr >> 4) >= ic) return int'(m_tpr);
        return ic << 4;
    endfunction

    function automatic bit exp_ready();
        int p;
        int pr;
        p  = top_of(m_irr);
        pr = exp_ppr();
        return m_spur[8] && (p >= 0) && ((pr == 0) || ((p >> 4) > (pr >> 4)));
    endfunction

    task automatic chk(bit ok, string tag, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s %s: actual=%0h expected=%0h", tag, req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // one cycle: drive at negedge, judge just before the next posedge, then advance the model
    task automatic cyc(bit sv, bit [7:0] svv, bit lvl, bit dv, bit [7:0] dvv,
                       bit tw, bit [7:0] tv, bit cw, bit [12:0] cv,
                       bit ak, bit eo, string tag);
        int  p, it, e_vec, e_eoi;
        bit  rdy, e_vld, e_spur, e_bc, grant, pop;
        @(negedge clk);
        set_vld = sv; set_vec = svv; set_level = lvl;
        deassert_vld = dv; deassert_vec = dvv;
        tpr_wr = tw; tpr_val = tv; cfg_wr = cw; cfg_val = cv;
        ack_req = ak; eoi_req = eo;
        #4;
        p   = top_of(m_irr);
        it  = top_of(m_isr);
        rdy = exp_ready();
        e_vld = 0; e_spur = 0; e_vec = 0; grant = 0;
        if (ak && m_spur[8] && p >= 0) begin
            e_vld = 1;
            if (rdy) begin e_vec = p; grant = 1; end
            else begin e_spur = 1; e_vec = int'(m_spur[7:0]); end
        end
        pop   = eo && (it >= 0);
        e_bc  = pop && m_tmr[it] && !m_sup;
        e_eoi = e_bc ? it : 0;
        chk(irq == rdy, tag, "R5", "irq", int'(irq), int'(rdy));
        chk(int'(ppr) == exp_ppr(), tag, "R4", "ppr", int'(ppr), exp_ppr());
        chk(ack_vld == e_vld && ack_spur == e_spur && int'(ack_vec) == e_vec, tag, "R8", "ack",
            {ack_vld, ack_spur, ack_vec}, {e_vld, e_spur, 8'(e_vec)});
        chk(eoi_bcast == e_bc && int'(eoi_vec) == e_eoi, tag, "R9", "eoi",
            {eoi_bcast, eoi_vec}, {e_bc, 8'(e_eoi)});
        // model update: clears first, sets last (R13)
        if (grant) m_irr[p] = 1'b0;
        if (dv)    m_irr[dvv] = 1'b0;
        if (pop)   m_isr[it] = 1'b0;
        if (grant) m_isr[p] = 1'b1;
        if (sv) begin
            m_irr[svv] = 1'b1;
            m_tmr[svv] = lvl;
        end
        if (tw) m_tpr = tv;
        if (cw) begin m_spur = cv[8:0]; m_sup = cv[12]; end
    endtask

    task automatic idle(string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic do_set(bit [7:0] v, bit lvl, string tag);
        cyc(1, v, lvl, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic do_ack(string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, tag);
    endtask
    task automatic do_eoi(string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
    endtask
    task automatic do_cfg(bit [12:0] v, string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, v, 0, 0, tag);
    endtask
    task automatic do_tpr(bit [7:0] v, string tag);
        cyc(0, 0, 0, 0, 0, 1, v, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = '0; m_spur = 9'h0FF; m_sup = 0;
        ack_req = 1'b1;
        #3;
        chk(irq == 0, "R1", "R1", "irq in reset", int'(irq), 0);
        chk(ppr == 0, "R1", "R1", "ppr in reset", int'(ppr), 0);
        chk(ack_vld == 0 && ack_vec == 0, "R1", "R1", "ack in reset", int'(ack_vec), 0);
        ack_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        do_set(8'h40, 0, "R2");
        idle("R11");
        do_ack("R11");
        do_cfg(13'h1FF, "R11");
        do_set(8'h90, 1, "R2");
        do_ack("R3");
        do_ack("R6");
        do_eoi("R9");
        do_ack("R8");
        do_eoi("R9");
        do_eoi("R10");
        idle("R10");
        do_tpr(8'h50, "R4");
        do_set(8'h55, 1, "R5");
        idle("R5");
        do_set(8'h60, 0, "R5");
        do_ack("R8");
        cyc(0, 0, 0, 1, 8'h55, 1, 8'h00, 0, 0, 0, 0, "R12");
        do_ack("R12");
        do_eoi("R4");
        do_cfg(13'h11FF, "R11");
        do_set(8'h70, 1, "R2");
        do_ack("R8");
        do_eoi("R9");
        do_cfg(13'h01C3, "R11");
        cyc(1, 8'h80, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R13");
        do_ack("R13");
        do_set(8'hA0, 1, "R2");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R13");
        idle("R13");
        cyc(1, 8'h33, 1, 1, 8'h33, 0, 0, 0, 0, 0, 0, "R13");
        do_ack("R13");
        do_tpr(8'hF0, "R4");
        do_ack("R6");
        do_tpr(8'h00, "R4");
        do_eoi("R9");
        do_eoi("R9");
        do_eoi("R10");

        for (int n = 0; n < 3000; n++) begin
            bit [12:0] cv;
            case ($urandom_range(0, 3))
                0: cv = 13'h00C5;
                1: cv = 13'h11FF;
                default: cv = 13'h01E7;
            endcase
            cyc($urandom_range(0, 99) < 40, 8'($urandom_range(32, 223)), 1'($urandom),
                $urandom_range(0, 99) < 15, 8'($urandom_range(32, 223)),
                $urandom_range(0, 99) < 8, 8'($urandom_range(0, 255)),
                $urandom_range(0, 99) < 3, cv,
                $urandom_range(0, 99) < 35, $urandom_range(0, 99) < 30, "R13");
        end

        summary();
        $finish;
    end
endmodule